// File: doc/BRIEF.md
# Input Clock Loss Detector

This block watches a monitored pixel clock from a free-running reference clock. It decides whether the monitored clock is running at a usable rate or has dropped out. The monitored clock is brought into the reference domain through a flop synchroniser. Its rising edges are then counted over fixed windows of reference cycles. A window passes when it holds at least one edge per microsecond of window length, so any input below about 1 MHz fails.

A run of consecutive windows with the same verdict is needed before the declared state changes. This hysteresis keeps a short glitch or a short burst from flipping the result. While the clock is declared lost and sleep-on-loss is enabled, the block requests a low-power state. When the clock comes back, it raises a one-cycle pulse that starts the downstream relock. The block drives nothing toward configuration storage, so settings survive any loss-and-recovery cycle.

Top module: `clk_loss_monitor`

## Requirements
- R1: After reset `clock_present_o` is 0, `relock_start_o` is 0, and `sleep_req_o` equals `sleep_en_i`. The clock counts as lost from reset.
- R2: The declared state goes from lost to present after 2 consecutive passing windows. A window is `REF_MHZ*WIN_US` reference cycles (200 by default) and passes with at least `WIN_US` synchronised rising edges (4 by default).
- R3: The declared state goes from present to lost after 2 consecutive failing windows.
- R4: A stall of the monitored clock that can fail only one window (300 reference cycles by default) leaves `clock_present_o` at 1 and raises no relock pulse.
- R5: A short burst of monitored edges while lost (5 edges) does not declare presence.
- R6: `sleep_req_o` is 1 exactly when the clock is declared lost and `sleep_en_i` is 1. It falls in the same cycle that `clock_present_o` rises.
- R7: `relock_start_o` is a one-cycle pulse, issued once per lost-to-present transition, in the first cycle `clock_present_o` is 1.
- R8: A monitored clock at 1.25 MHz is declared present. One at 0.625 MHz is declared lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mon_clk_i | input | 1 | Monitored clock, asynchronous to clk_i |
| sleep_en_i | input | 1 | Enables the sleep request on loss |
| clock_present_o | output | 1 | 1 while the monitored clock is declared running |
| sleep_req_o | output | 1 | Low-power request while lost and enabled |
| relock_start_o | output | 1 | One-cycle pulse on the return of the clock |

## Verification
A corrupted window counter or a bad pass threshold shows up as a wrong verdict at `clock_present_o`. This is visible within three windows of the change in stimulus, about 600 reference cycles, so each stimulus phase is held for five windows before sampling. A broken run counter shows up in the one-window stall and the short-burst phases. Presence either drops or rises when it should not, and a spurious or missing `relock_start_o` pulse goes with it. Errors in the sleep gating are visible at once, because `sleep_req_o` is compared every cycle.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic {
        LINK_LOST    = 1'b0,
        LINK_PRESENT = 1'b1
    } presence_e;

    typedef struct packed {
        logic done;
        logic pass;
    } win_result_t;

    function automatic int unsigned width_of(input int unsigned count);
        return (count < 2) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/clkmon_edge.sv
module clkmon_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mon_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q[g] <= 1'b0;
                else if (g == 0) chain_q[g] <= mon_i;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/clkmon_window.sv
module clkmon_window
    import clkmon_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 200,
    parameter int unsigned MIN_EDGES  = 4
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        rise_i,
    output win_result_t result_o
);
    localparam int unsigned CW = width_of(WIN_CYCLES);
    localparam int unsigned EW = width_of(MIN_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);
    localparam logic [EW-1:0] NEED = EW'(MIN_EDGES);

    logic [CW-1:0] cyc_q;
    logic [EW-1:0] edges_q, edges_next;

    // Saturating edge tally: it only has to reach the threshold.
    always_comb begin
        edges_next = edges_q;
        if (rise_i && edges_q != NEED) edges_next = edges_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cyc_q    <= '0;
            edges_q  <= '0;
            result_o <= '0;
        end else begin
            result_o.done <= 1'b0;
            if (cyc_q == LAST) begin
                cyc_q         <= '0;
                edges_q       <= '0;
                result_o.done <= 1'b1;
                result_o.pass <= (edges_next >= NEED);
            end else begin
                cyc_q   <= cyc_q + 1'b1;
                edges_q <= edges_next;
            end
        end
    end
endmodule

// File: rtl/clkmon_decide.sv
module clkmon_decide
    import clkmon_pkg::*;
#(
    parameter int unsigned RUN_LEN = 2
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  win_result_t win_i,
    input  logic        sleep_en_i,
    output logic        present_o,
    output logic        sleep_req_o,
    output logic        relock_o
);
    localparam int unsigned RW = width_of(RUN_LEN);
    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);

    presence_e   state_q;
    logic [RW-1:0] run_q;   // consecutive windows disagreeing with state

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= LINK_LOST;
            run_q    <= '0;
            relock_o <= 1'b0;
        end else begin
            relock_o <= 1'b0;
            if (win_i.done) begin
                if (win_i.pass == (state_q == LINK_PRESENT)) begin
                    run_q <= '0;
                end else if (run_q == RUN_LAST) begin
                    run_q <= '0;
                    if (state_q == LINK_LOST) begin
                        state_q  <= LINK_PRESENT;
                        relock_o <= 1'b1;
                    end else begin
                        state_q <= LINK_LOST;
                    end
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    assign present_o   = (state_q == LINK_PRESENT);
    assign sleep_req_o = (state_q == LINK_LOST) && sleep_en_i;
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
    import clkmon_pkg::*;
#(
    parameter int unsigned REF_MHZ         = 50,
    parameter int unsigned WIN_US          = 4,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned CONFIRM_WINDOWS = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mon_clk_i,
    input  logic sleep_en_i,
    output logic clock_present_o,
    output logic sleep_req_o,
    output logic relock_start_o
);
    localparam int unsigned WIN_CYCLES = REF_MHZ * WIN_US;
    localparam int unsigned MIN_EDGES  = WIN_US;

    logic        rise;
    win_result_t win;

    clkmon_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .mon_i (mon_clk_i),
        .rise_o(rise)
    );

    clkmon_window #(.WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES)) u_window (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rise_i  (rise),
        .result_o(win)
    );

    clkmon_decide #(.RUN_LEN(CONFIRM_WINDOWS)) u_decide (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .win_i      (win),
        .sleep_en_i (sleep_en_i),
        .present_o  (clock_present_o),
        .sleep_req_o(sleep_req_o),
        .relock_o   (relock_start_o)
    );
endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk (
    input logic clk_i,
    input logic rst_i,
    input logic sleep_en_i,
    input logic clock_present_o,
    input logic sleep_req_o,
    input logic relock_start_o
);
    // R7: the pulse marks the first present cycle after a lost one
    assert_relock_on_rise_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        relock_start_o |-> (clock_present_o && !$past(clock_present_o)));

    // R7: never two cycles wide
    assert_relock_single_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        relock_start_o |=> !relock_start_o);

    // R7: every return of the clock carries a pulse
    assert_rise_has_relock_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(clock_present_o) |-> relock_start_o);

    // R6: sleep request cleared in the cycle presence is declared
    assert_sleep_drops_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(clock_present_o) |-> !sleep_req_o);

    // R6: no sleep request while present or disabled
    assert_sleep_gated_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        sleep_req_o |-> (!clock_present_o && sleep_en_i));

    // R3: losing the clock never raises a relock pulse
    assert_no_relock_on_loss_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(clock_present_o) |-> !relock_start_o);
endmodule

bind clk_loss_monitor clk_loss_monitor_chk u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .sleep_en_i     (sleep_en_i),
    .clock_present_o(clock_present_o),
    .sleep_req_o    (sleep_req_o),
    .relock_start_o (relock_start_o)
);

// File: tb/tb_clk_loss_monitor.sv
module tb_clk_loss_monitor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mon_clk = 1'b0;
    logic sleep_en = 1'b1;
    logic clock_present, sleep_req, relock_start;

    always #10 clk = ~clk;   // 50 MHz

    clk_loss_monitor dut (
        .clk_i          (clk),
        .rst_i          (rst),
        .mon_clk_i      (mon_clk),
        .sleep_en_i     (sleep_en),
        .clock_present_o(clock_present),
        .sleep_req_o    (sleep_req),
        .relock_start_o (relock_start)
    );

    typedef struct {
        logic  present;
        logic  sleep;
        int    relocks;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int relock_seen = 0;
    int mon_half = 0;   // reference cycles per half period, 0 = stopped
    int phase = 0;
    bit done = 1'b0;

    // Monitored clock generator, changes just after the reference edge.
    initial forever begin
        @(posedge clk);
        #2;
        if (mon_half == 0) begin
            mon_clk = 1'b0;
            phase = 0;
        end else begin
            phase++;
            if (phase >= mon_half) begin
                phase = 0;
                mon_clk = ~mon_clk;
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic expect_state(input logic p, input logic s, input int r, input string tag);
        exp_t e;
        e.present = p; e.sleep = s; e.relocks = r; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: scoreboard comparison and continuous output checks.
    logic prev_relock = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (relock_start) begin
                relock_seen++;
                checks++;
                if (prev_relock || !clock_present) begin
                    errors++;
                    $display("FAIL R7 pulse: relock=%0b prev=%0b present=%0b expected single pulse while present",
                             relock_start, prev_relock, clock_present);
                end
            end
            if (sleep_req !== (!clock_present && sleep_en)) begin
                checks++;
                errors++;
                $display("FAIL R6 sleep_req=%0b expected %0b", sleep_req, !clock_present && sleep_en);
            end
            prev_relock = relock_start;
        end
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (clock_present !== e.present || sleep_req !== e.sleep || relock_seen != e.relocks) begin
                errors++;
                $display("FAIL %s: present=%0b sleep=%0b relocks=%0d expected present=%0b sleep=%0b relocks=%0d",
                         e.tag, clock_present, sleep_req, relock_seen, e.present, e.sleep, e.relocks);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        cycles(150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        cycles(5);
        rst = 1'b0;
        // R1: reset state, clock treated as lost
        expect_state(1'b0, 1'b1, 0, "R1 reset");
        sleep_en = 1'b0;
        cycles(2);
        expect_state(1'b0, 1'b0, 0, "R1 sleep follows enable");
        sleep_en = 1'b1;
        cycles(2);
        expect_state(1'b0, 1'b1, 0, "R6 lost and enabled");

        // R2: a fast clock becomes present after two passing windows
        mon_half = 2;
        cycles(1000);
        expect_state(1'b1, 1'b0, 1, "R2 fast clock present");

        // R8: just above threshold stays present
        mon_half = 20;
        cycles(1000);
        expect_state(1'b1, 1'b0, 1, "R8 1.25MHz present");

        // R4: a stall failing only one window is tolerated
        mon_half = 2;
        cycles(400);
        mon_half = 0;
        cycles(300);
        mon_half = 2;
        cycles(1000);
        expect_state(1'b1, 1'b0, 1, "R4 single failing window");

        // R3: clock stops, loss after two failing windows
        mon_half = 0;
        cycles(1000);
        expect_state(1'b0, 1'b1, 1, "R3 stopped clock lost");

        // R6: sleep request gated by the enable
        sleep_en = 1'b0;
        cycles(3);
        expect_state(1'b0, 1'b0, 1, "R6 sleep disabled");
        sleep_en = 1'b1;
        cycles(3);
        expect_state(1'b0, 1'b1, 1, "R6 sleep re-enabled");

        // R5: a short burst cannot declare presence
        mon_half = 2;
        cycles(20);
        mon_half = 0;
        cycles(1000);
        expect_state(1'b0, 1'b1, 1, "R5 burst ignored");

        // R8: below threshold stays lost
        mon_half = 40;
        cycles(1000);
        expect_state(1'b0, 1'b1, 1, "R8 0.625MHz lost");

        // R7: clock returns, one more relock pulse
        mon_half = 2;
        cycles(1000);
        expect_state(1'b1, 1'b0, 2, "R7 second relock");

        checks++;
        if (relock_seen != 2) begin
            errors++;
            $display("FAIL R7 relock total=%0d expected 2", relock_seen);
        end
        cycles(4);
        finish_run();
    end
endmodule